// File: doc/BRIEF.md
# Wiper Position Register and Tap Decoder

This block holds the volatile position of a 64-step resistor wiper. It drives one select line per tap of the resistor chain, and exactly one of those lines is active at any time. The position can come from four sources. A neighbouring non-volatile store supplies the power-on value. A command decoder can request a copy of a chosen stored word, or write a value taken from the serial link. Single-step pulses move the wiper by one segment. Write protection of the non-volatile store does not reach this register, so none of its loads is gated.

Every load is a single-cycle strobe sampled on the rising clock edge. The block has no back-pressure: a strobe is always taken in the cycle it is seen. When strobes coincide, the highest-priority one decides the new value. The current position stays on `pos` at all times, for read-back and for storing into a data word. The analogue resistor network sits outside this block.

Top module: `wiper_pos_reg`

## Requirements
- R1: While `rst_n` is low, `pos` is 0 and only `tap_sel[0]` is high. On the first rising edge after `rst_n` goes high, the block loads `dr0_val` without any strobe, so the volatile register starts from stored word 0.
- R2: When `recall_req` is high at a rising edge, `pos` equals `dr0_val` after that edge.
- R3: When `xfer_load` is high at a rising edge, `pos` equals `xfer_val` after that edge.
- R4: When `wr_load` is high at a rising edge, `pos` equals `wr_val` after that edge.
- R5: When `step_en` is high at a rising edge, `pos` moves one step: up by 1 if `step_up` is 1 (toward the high terminal), down by 1 if `step_up` is 0 (toward the low terminal).
- R6: Steps saturate. An up-step at 63 leaves 63, and a down-step at 0 leaves 0. There is no wrap-around.
- R7: Priority when strobes coincide: power-on or requested recall first, then transfer, then serial write, then step. The pending power-on recall also beats any strobe in its cycle.
- R8: `tap_sel` is one-hot and its active bit index equals `pos`. Bit 0 is the low terminal (value 00h) and bit 63 is the high terminal (value 3Fh).
- R9: With no strobe and no pending recall, `pos` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| recall_req | input | 1 | Strobe: reload stored word 0 |
| dr0_val | input | 6 | Contents of stored word 0 |
| xfer_load | input | 1 | Strobe: parallel copy of selected stored word |
| xfer_val | input | 6 | Selected stored word for the copy |
| wr_load | input | 1 | Strobe: serial write of a new position |
| wr_val | input | 6 | Value from the serial write |
| step_en | input | 1 | Strobe: one-segment step |
| step_up | input | 1 | Step direction, 1 toward high terminal |
| pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | One-hot tap switch enables |

## Verification
Each load or step shows up on `pos` one clock edge after its strobe is sampled. `tap_sel` follows `pos` in the same cycle through pure logic. The bench drives strobes on the falling edge, waits for the next rising edge, and compares both outputs 1 ns later, before anything else changes. The power-on recall is checked at the first rising edge after reset release, with a conflicting write strobe present in that same cycle.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_RECALL,
    SRC_XFER,
    SRC_WRITE,
    SRC_STEP
  } wpr_src_e;
endpackage

// File: rtl/wpr_load_arb.sv
module wpr_load_arb
  import wpr_pkg::*;
(
  input  logic     recall,
  input  logic     xfer,
  input  logic     wr,
  input  logic     step,
  output wpr_src_e src
);
  // fixed priority: recall > transfer > write > step
  always_comb begin
    if (recall)    src = SRC_RECALL;
    else if (xfer) src = SRC_XFER;
    else if (wr)   src = SRC_WRITE;
    else if (step) src = SRC_STEP;
    else           src = SRC_HOLD;
  end
endmodule

// File: rtl/wpr_step.sv
module wpr_step #(
  parameter int POS_W = 6
) (
  input  logic [POS_W-1:0] cur,
  input  logic             up,
  output logic [POS_W-1:0] nxt
);
  localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] BOT = '0;
  localparam logic [POS_W-1:0] ONE = {{(POS_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (up) nxt = (cur == TOP) ? cur : cur + ONE;
    else    nxt = (cur == BOT) ? cur : cur - ONE;
  end
endmodule

// File: rtl/wpr_tap_decode.sv
module wpr_tap_decode #(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam logic [POS_W-1:0] IDX = i[POS_W-1:0];
    assign tap[i] = (pos == IDX);
  end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wpr_pkg::*;
#(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recall_req,
  input  logic [POS_W-1:0] dr0_val,
  input  logic             xfer_load,
  input  logic [POS_W-1:0] xfer_val,
  input  logic             wr_load,
  input  logic [POS_W-1:0] wr_val,
  input  logic             step_en,
  input  logic             step_up,
  output logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap_sel
);
  logic             recall_pend;
  logic [POS_W-1:0] step_nxt;
  logic [POS_W-1:0] pos_nxt;
  wpr_src_e         src;

  // power-up recall pending for exactly the first cycle after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recall_pend <= 1'b1;
    else        recall_pend <= 1'b0;
  end

  wpr_load_arb u_arb (
    .recall (recall_pend | recall_req),
    .xfer   (xfer_load),
    .wr     (wr_load),
    .step   (step_en),
    .src    (src)
  );

  wpr_step #(.POS_W(POS_W)) u_step (
    .cur (pos),
    .up  (step_up),
    .nxt (step_nxt)
  );

  always_comb begin
    unique case (src)
      SRC_RECALL: pos_nxt = dr0_val;
      SRC_XFER:   pos_nxt = xfer_val;
      SRC_WRITE:  pos_nxt = wr_val;
      SRC_STEP:   pos_nxt = step_nxt;
      default:    pos_nxt = pos;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_nxt;
  end

  wpr_tap_decode #(.POS_W(POS_W)) u_dec (
    .pos (pos),
    .tap (tap_sel)
  );
endmodule

// File: rtl/wpr_chk.sv
module wpr_chk #(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             recall_pend,
  input logic             recall_req,
  input logic [POS_W-1:0] dr0_val,
  input logic             xfer_load,
  input logic [POS_W-1:0] xfer_val,
  input logic             wr_load,
  input logic [POS_W-1:0] wr_val,
  input logic             step_en,
  input logic             step_up,
  input logic [POS_W-1:0] pos,
  input logic [TAPS-1:0]  tap_sel
);
  localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1 && tap_sel[pos]); // R8
  AST_RECALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_pend || recall_req) |=> pos == $past(dr0_val)); // R2
  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_load && !recall_pend && !recall_req) |=> pos == $past(xfer_val)); // R3
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && !xfer_load && !recall_pend && !recall_req) |=> pos == $past(wr_val)); // R4
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && pos == TOP && !wr_load && !xfer_load && !recall_pend && !recall_req)
    |=> pos == TOP); // R6
  AST_SAT_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && pos == '0 && !wr_load && !xfer_load && !recall_pend && !recall_req)
    |=> pos == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !wr_load && !xfer_load && !recall_pend && !recall_req) |=> $stable(pos)); // R9
endmodule

bind wiper_pos_reg wpr_chk #(.POS_W(POS_W)) u_chk (.*);

// File: tb/tb_wiper_pos_reg.sv
module tb_wiper_pos_reg;
  localparam int W = 6;
  localparam int T = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recall_req = 0, xfer_load = 0, wr_load = 0, step_en = 0, step_up = 0;
  logic [W-1:0] dr0_val = '0, xfer_val = '0, wr_val = '0;
  logic [W-1:0] pos;
  logic [T-1:0] tap_sel;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  wiper_pos_reg #(.POS_W(W)) dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_pos(string req, int exp);
    check(req, 64'(pos), 64'(exp));
    check({req, "/R8"}, 64'(tap_sel), 64'(1) << exp);
  endtask

  // called at a falling edge; leaves time 1 ns after the next rising edge
  task automatic op(bit rc, bit xf, bit wr, bit st, bit up,
                    int dv, int xv, int wv);
    recall_req = rc; xfer_load = xf; wr_load = wr; step_en = st; step_up = up;
    dr0_val = W'(dv); xfer_val = W'(xv); wr_val = W'(wv);
    @(posedge clk); #1;
    recall_req = 0; xfer_load = 0; wr_load = 0; step_en = 0;
  endtask

  initial begin
    #800000;
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int exp;
    // R1: reset state, then power-on recall
    dr0_val = 6'h2A;
    repeat (3) @(posedge clk);
    #1 check_pos("R1 reset", 0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    check_pos("R1 power-on recall", 'h2A);
    // R9: idle holds
    repeat (3) @(posedge clk);
    #1 check_pos("R9 idle hold", 'h2A);

    // R7: power-on recall beats a coincident write
    @(negedge clk) rst_n = 0;
    #1 check_pos("R1 reset again", 0);
    @(negedge clk) begin rst_n = 1; dr0_val = 6'h15; wr_load = 1; wr_val = 6'h3C; end
    @(posedge clk); #1; wr_load = 0;
    check_pos("R7 power-on recall over write", 'h15);

    // R4, R8: all write values
    for (int v = 0; v < T; v++) begin
      @(negedge clk) op(0, 0, 1, 0, 0, 0, 0, v);
      check_pos("R4 write", v);
    end
    // R3: all transfer values
    for (int v = 0; v < T; v++) begin
      @(negedge clk) op(0, 1, 0, 0, 0, 0, T - 1 - v, 0);
      check_pos("R3 transfer", T - 1 - v);
    end
    // R2: recall strobe
    for (int v = 0; v < T; v += 7) begin
      @(negedge clk) op(1, 0, 0, 0, 0, v, 0, 0);
      check_pos("R2 recall", v);
    end

    // R5, R6: step sweep up past top, then down past bottom
    @(negedge clk) op(0, 0, 1, 0, 0, 0, 0, 0);
    exp = 0;
    for (int k = 0; k < T + 6; k++) begin
      @(negedge clk) op(0, 0, 0, 1, 1, 0, 0, 0);
      exp = (exp == T - 1) ? exp : exp + 1;
      check_pos(exp == T - 1 ? "R6 saturate up" : "R5 step up", exp);
    end
    for (int k = 0; k < T + 6; k++) begin
      @(negedge clk) op(0, 0, 0, 1, 0, 0, 0, 0);
      exp = (exp == 0) ? exp : exp - 1;
      check_pos(exp == 0 ? "R6 saturate down" : "R5 step down", exp);
    end

    // R7: every combination of the four strobes
    for (int m = 0; m < 16; m++) begin
      @(negedge clk) op(0, 0, 1, 0, 0, 0, 0, 20);
      @(negedge clk) op(m[3], m[2], m[1], m[0], 1, 11, 33, 44);
      exp = m[3] ? 11 : m[2] ? 33 : m[1] ? 44 : m[0] ? 21 : 20;
      check_pos("R7 priority", exp);
    end

    // R9: inputs changing without strobes have no effect
    @(negedge clk) op(0, 0, 1, 0, 0, 0, 0, 9);
    @(negedge clk) op(0, 0, 0, 0, 1, 50, 51, 52);
    check_pos("R9 no strobe", 9);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule